// File: doc/BRIEF.md
# Dual Exposure Row Pair Scheduler

This block sequences a wide-dynamic-range capture in which every output frame is built from two integration times. A long one keeps shadow detail and a short one keeps highlights. During each row slot the block names two physical rows. The long-exposure row is the slot index n. The short-exposure row sits a programmable offset behind it and wraps around the frame height. The readout front end fills an upper holding bank with the long row and a lower holding bank with the short row, one column per write strobe.

Once both banks hold a complete row, the block drains them as a stream of column pairs under a valid/ready handshake. Each beat carries the column index, both row indices, a flag telling whether the short row is a real row of this frame, and the two sample values. The next slot opens only after the last pair of the current slot has been accepted. A downstream merger can therefore realign every value by its tag. Merging the exposures is left to that downstream logic.

Top module: `dual_exposure_pair_sched`

## Requirements
- R1: After reset, busy, filling, out_valid and frame_done are all 0.
- R2: A start pulse while idle latches the row count and offset and opens slot 0 on the next cycle. Row count 0 is taken as 1 and values above MAX_ROWS as MAX_ROWS. A start pulse while busy has no effect.
- R3: The long row index slot_long_row equals the slot number and advances by one per slot, from 0 to rows-1.
- R4: When n >= offset, the short row is n-offset and slot_short_ok is 1. Otherwise the short row is n+rows-offset and slot_short_ok is 0. An offset above rows-1 is taken as rows-1.
- R5: While filling, wr_up stores wr_data into upper column wr_col and wr_lo stores it into lower column wr_col. A later write to the same column replaces the earlier one.
- R6: Draining (out_valid=1) begins on the second cycle after the write that completes the row. The row is complete when every upper column 0..NCOLS-1 has been written, and every lower column too unless slot_short_ok is 0. Writes with wr_col >= NCOLS mark nothing, and a partial row never produces out_valid.
- R7: When slot_short_ok is 0, lower-bank writes are ignored and every beat of that slot carries out_lower = 0 and out_short_ok = 0.
- R8: The beats of a slot come in column order 0..NCOLS-1. Each carries out_col, out_long_row, out_short_row, out_short_ok, the upper value of that column and the lower value of that column.
- R9: While out_valid is 1 and out_ready is 0, the beat stays valid and unchanged, and no pair is skipped.
- R10: Bank writes outside the filling phase are ignored.
- R11: The cycle after the last beat of a slot is accepted, the next slot is filling with out_valid 0. After the last slot, frame_done is 1 for exactly one cycle and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start pulse |
| cfg_rows | input | ROW_W | Rows per frame |
| cfg_offset | input | ROW_W | Row distance between the long and short sweeps |
| busy | output | 1 | Frame in progress |
| filling | output | 1 | Banks accept writes |
| slot_long_row | output | ROW_W | Long-exposure row of the current slot |
| slot_short_row | output | ROW_W | Short-exposure row of the current slot |
| slot_short_ok | output | 1 | Short row belongs to this frame |
| wr_up | input | 1 | Upper bank write strobe |
| wr_lo | input | 1 | Lower bank write strobe |
| wr_col | input | COL_W | Column of the write |
| wr_data | input | DW | Sample written |
| out_valid | output | 1 | Pair beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_col | output | COL_W | Column of the beat |
| out_long_row | output | ROW_W | Row tag of the upper value |
| out_short_row | output | ROW_W | Row tag of the lower value |
| out_short_ok | output | 1 | Lower value is a real sample |
| out_upper | output | DW | Long-exposure value |
| out_lower | output | DW | Short-exposure value |
| frame_done | output | 1 | One-cycle end of frame pulse |

## Verification
The hardest case to reach is a slot whose short row wraps past the top of the frame, combined with a stalled beat and a stray bank write arriving during that stall. The stimulus table holds row/offset pairs chosen so that several leading slots wrap, including an offset that is clamped. Every slot is filled in reverse column order, with one early value overwritten, an out-of-range column written and the completing column held back until partial-row silence has been observed. During the drain, ready is withheld on a rotating set of beats while garbage is written into the banks, and the bench then checks that the held beat did not move.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    typedef struct packed {
        logic        ok;
        logic [15:0] row;
    } short_t;

    // Short sweep trails the long one; wraps around the frame height.
    function automatic short_t short_of(input logic [15:0] n,
                                        input logic [15:0] off,
                                        input logic [15:0] rows);
        short_t s;
        if (n >= off) begin
            s.ok  = 1'b1;
            s.row = n - off;
        end else begin
            s.ok  = 1'b0;
            s.row = n + rows - off;
        end
        return s;
    endfunction

    function automatic logic [15:0] clamp_rows(input logic [15:0] req,
                                               input logic [15:0] max_rows);
        if (req == 16'd0)
            return 16'd1;
        else if (req > max_rows)
            return max_rows;
        else
            return req;
    endfunction

endpackage

// File: rtl/dxs_row_sched.sv
module dxs_row_sched
    import dxs_pkg::*;
#(
    parameter int MAX_ROWS = 12,
    parameter int ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [ROW_W-1:0] cfg_offset,
    input  logic             fill_done,
    input  logic             drain_last,
    output phase_e           phase,
    output logic [ROW_W-1:0] long_row,
    output logic [ROW_W-1:0] short_row,
    output logic             short_ok,
    output logic             slot_clear,
    output logic             frame_done
);

    phase_e           ph_q;
    logic [ROW_W-1:0] rows_q;
    logic [ROW_W-1:0] off_q;
    logic [ROW_W-1:0] n_q;
    logic             done_q;
    logic [ROW_W-1:0] rows_eff;
    logic [ROW_W-1:0] off_eff;
    logic             last_slot;
    short_t           sh;

    always_comb begin
        rows_eff = ROW_W'(clamp_rows(16'(cfg_rows), 16'(MAX_ROWS)));
        if (cfg_offset > rows_eff - 1'b1)
            off_eff = rows_eff - 1'b1;
        else
            off_eff = cfg_offset;
    end

    assign last_slot  = (n_q == rows_q - 1'b1);
    assign slot_clear = ((ph_q == PH_IDLE) && start) ||
                        ((ph_q == PH_DRAIN) && drain_last && !last_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            rows_q <= '0;
            off_q  <= '0;
            n_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        rows_q <= rows_eff;
                        off_q  <= off_eff;
                        n_q    <= '0;
                        ph_q   <= PH_FILL;
                    end
                end
                PH_FILL: begin
                    if (fill_done)
                        ph_q <= PH_DRAIN;
                end
                PH_DRAIN: begin
                    if (drain_last) begin
                        if (last_slot) begin
                            ph_q   <= PH_IDLE;
                            n_q    <= '0;
                            done_q <= 1'b1;
                        end else begin
                            n_q  <= n_q + 1'b1;
                            ph_q <= PH_FILL;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign sh         = short_of(16'(n_q), 16'(off_q), 16'(rows_q));
    assign phase      = ph_q;
    assign long_row   = n_q;
    assign short_row  = sh.row[ROW_W-1:0];
    assign short_ok   = sh.ok;
    assign frame_done = done_q;

endmodule

// File: rtl/dxs_hold_bank.sv
module dxs_hold_bank #(
    parameter int NCOLS = 6,
    parameter int COL_W = 3,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             we,
    input  logic [COL_W-1:0] wcol,
    input  logic [DW-1:0]    wdata,
    input  logic [COL_W-1:0] rcol,
    output logic [DW-1:0]    rdata,
    output logic             full
);

    logic [DW-1:0] mem_q [NCOLS];
    logic [NCOLS-1:0] seen_q;

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (we && (int'(wcol) == c))
                mem_q[c] <= wdata;
        end

        always_ff @(posedge clk) begin
            if (rst || clear)
                seen_q[c] <= 1'b0;
            else if (we && (int'(wcol) == c))
                seen_q[c] <= 1'b1;
        end
    end

    assign rdata = mem_q[rcol];
    assign full  = &seen_q;

endmodule

// File: rtl/dxs_pair_drain.sv
module dxs_pair_drain #(
    parameter int NCOLS = 6,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ready,
    output logic             valid,
    output logic [COL_W-1:0] col,
    output logic             last
);

    logic [COL_W-1:0] col_q;
    logic             fire;

    assign valid = en;
    assign fire  = en && ready;
    assign last  = fire && (col_q == COL_W'(NCOLS - 1));
    assign col   = col_q;

    always_ff @(posedge clk) begin
        if (rst)
            col_q <= '0;
        else if (last)
            col_q <= '0;
        else if (fire)
            col_q <= col_q + 1'b1;
    end

endmodule

// File: rtl/dual_exposure_pair_sched.sv
module dual_exposure_pair_sched
    import dxs_pkg::*;
#(
    parameter int NCOLS    = 6,
    parameter int MAX_ROWS = 12,
    parameter int DW       = 16,
    localparam int COL_W   = (NCOLS > 1) ? $clog2(NCOLS) : 1,
    localparam int ROW_W   = $clog2(MAX_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [ROW_W-1:0] cfg_offset,
    output logic             busy,
    output logic             filling,
    output logic [ROW_W-1:0] slot_long_row,
    output logic [ROW_W-1:0] slot_short_row,
    output logic             slot_short_ok,
    input  logic             wr_up,
    input  logic             wr_lo,
    input  logic [COL_W-1:0] wr_col,
    input  logic [DW-1:0]    wr_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [COL_W-1:0] out_col,
    output logic [ROW_W-1:0] out_long_row,
    output logic [ROW_W-1:0] out_short_row,
    output logic             out_short_ok,
    output logic [DW-1:0]    out_upper,
    output logic [DW-1:0]    out_lower,
    output logic             frame_done
);

    phase_e           phase;
    logic             slot_clear;
    logic             fill_done;
    logic             drain_last;
    logic             col_in_range;
    logic             up_we;
    logic             lo_we;
    logic             up_full;
    logic             lo_full;
    logic [DW-1:0]    up_rd;
    logic [DW-1:0]    lo_rd;
    logic [COL_W-1:0] rd_col;
    logic [ROW_W-1:0] long_row;
    logic [ROW_W-1:0] short_row;
    logic             short_ok;

    dxs_row_sched #(
        .MAX_ROWS (MAX_ROWS),
        .ROW_W    (ROW_W)
    ) u_sched (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_rows   (cfg_rows),
        .cfg_offset (cfg_offset),
        .fill_done  (fill_done),
        .drain_last (drain_last),
        .phase      (phase),
        .long_row   (long_row),
        .short_row  (short_row),
        .short_ok   (short_ok),
        .slot_clear (slot_clear),
        .frame_done (frame_done)
    );

    assign filling      = (phase == PH_FILL);
    assign busy         = (phase != PH_IDLE);
    assign col_in_range = (int'(wr_col) < NCOLS);
    assign up_we        = filling && wr_up && col_in_range;
    assign lo_we        = filling && wr_lo && col_in_range && short_ok;
    assign fill_done    = up_full && (lo_full || !short_ok);

    dxs_hold_bank #(.NCOLS(NCOLS), .COL_W(COL_W), .DW(DW)) u_upper (
        .clk   (clk),
        .rst   (rst),
        .clear (slot_clear),
        .we    (up_we),
        .wcol  (wr_col),
        .wdata (wr_data),
        .rcol  (rd_col),
        .rdata (up_rd),
        .full  (up_full)
    );

    dxs_hold_bank #(.NCOLS(NCOLS), .COL_W(COL_W), .DW(DW)) u_lower (
        .clk   (clk),
        .rst   (rst),
        .clear (slot_clear),
        .we    (lo_we),
        .wcol  (wr_col),
        .wdata (wr_data),
        .rcol  (rd_col),
        .rdata (lo_rd),
        .full  (lo_full)
    );

    dxs_pair_drain #(.NCOLS(NCOLS), .COL_W(COL_W)) u_drain (
        .clk   (clk),
        .rst   (rst),
        .en    (phase == PH_DRAIN),
        .ready (out_ready),
        .valid (out_valid),
        .col   (rd_col),
        .last  (drain_last)
    );

    assign slot_long_row  = long_row;
    assign slot_short_row = short_row;
    assign slot_short_ok  = short_ok;
    assign out_col        = rd_col;
    assign out_long_row   = long_row;
    assign out_short_row  = short_row;
    assign out_short_ok   = short_ok;
    assign out_upper      = up_rd;
    assign out_lower      = short_ok ? lo_rd : '0;

endmodule

// File: rtl/dxs_checker.sv
module dxs_checker #(
    parameter int NCOLS = 6,
    parameter int COL_W = 3,
    parameter int ROW_W = 4,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             filling,
    input logic [ROW_W-1:0] slot_long_row,
    input logic [ROW_W-1:0] slot_short_row,
    input logic             slot_short_ok,
    input logic             out_valid,
    input logic             out_ready,
    input logic [COL_W-1:0] out_col,
    input logic [ROW_W-1:0] out_long_row,
    input logic [ROW_W-1:0] out_short_row,
    input logic             out_short_ok,
    input logic [DW-1:0]    out_upper,
    input logic [DW-1:0]    out_lower,
    input logic             frame_done
);

    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_col) &&
            $stable(out_upper) && $stable(out_lower) && $stable(out_long_row)));

    assert_column_order_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && (int'(out_col) != NCOLS - 1)) |=>
            (out_valid && out_col == COL_W'($past(out_col) + 1'b1)));

    assert_no_fill_while_drain_R11: assert property (@(posedge clk) disable iff (rst)
        filling |-> !out_valid);

    assert_done_is_idle_R11: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!busy && !out_valid));

    assert_wrap_above_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !slot_short_ok) |-> (slot_short_row > slot_long_row));

    assert_trail_below_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && slot_short_ok) |-> (slot_short_row <= slot_long_row));

    assert_lower_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_short_ok) |-> (out_lower == '0));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

bind dual_exposure_pair_sched dxs_checker #(
    .NCOLS (NCOLS),
    .COL_W (COL_W),
    .ROW_W (ROW_W),
    .DW    (DW)
) u_chk (.*);

// File: tb/dual_exposure_pair_sched_tb.sv
module dual_exposure_pair_sched_tb;

    localparam int NCOLS    = 6;
    localparam int MAX_ROWS = 12;
    localparam int DW       = 16;
    localparam int COL_W    = 3;
    localparam int ROW_W    = 4;
    localparam int NVEC     = 5;

    // {requested rows, requested offset, effective rows, effective offset}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd4, 8'd1, 8'd4, 8'd1},
        {8'd3, 8'd0, 8'd3, 8'd0},
        {8'd5, 8'd3, 8'd5, 8'd3},
        {8'd3, 8'd7, 8'd3, 8'd2},
        {8'd0, 8'd0, 8'd1, 8'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [ROW_W-1:0] cfg_rows = '0;
    logic [ROW_W-1:0] cfg_offset = '0;
    logic             busy, filling, slot_short_ok;
    logic [ROW_W-1:0] slot_long_row, slot_short_row;
    logic             wr_up = 1'b0;
    logic             wr_lo = 1'b0;
    logic [COL_W-1:0] wr_col = '0;
    logic [DW-1:0]    wr_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [COL_W-1:0] out_col;
    logic [ROW_W-1:0] out_long_row, out_short_row;
    logic             out_short_ok;
    logic [DW-1:0]    out_upper, out_lower;
    logic             frame_done;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dual_exposure_pair_sched #(
        .NCOLS(NCOLS), .MAX_ROWS(MAX_ROWS), .DW(DW)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_rows(cfg_rows),
        .cfg_offset(cfg_offset), .busy(busy), .filling(filling),
        .slot_long_row(slot_long_row), .slot_short_row(slot_short_row),
        .slot_short_ok(slot_short_ok), .wr_up(wr_up), .wr_lo(wr_lo),
        .wr_col(wr_col), .wr_data(wr_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_col(out_col), .out_long_row(out_long_row),
        .out_short_row(out_short_row), .out_short_ok(out_short_ok),
        .out_upper(out_upper), .out_lower(out_lower), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic int up_val(input int row, input int col);
        return 32'h1000 | (row << 4) | col;
    endfunction

    function automatic int lo_val(input int row, input int col);
        return 32'h2000 | (row << 4) | col;
    endfunction

    task automatic write_both(input int col, input int uv, input int lv);
        wr_up = 1'b1; wr_lo = 1'b0; wr_col = COL_W'(col); wr_data = DW'(uv);
        cyc();
        wr_up = 1'b0; wr_lo = 1'b1; wr_data = DW'(lv);
        cyc();
        wr_lo = 1'b0;
    endtask

    task automatic run_frame(input int req_rows, input int req_off,
                             input int rows, input int off);
        int sr;
        bit sok;
        cfg_rows = ROW_W'(req_rows);
        cfg_offset = ROW_W'(req_off);
        start = 1'b1;
        cyc();
        start = 1'b0;
        check(filling === 1'b1 && busy === 1'b1, "R2 slot0 opens", filling, 1);
        for (int n = 0; n < rows; n++) begin
            sok = (n >= off);
            sr  = sok ? n - off : n + rows - off;
            check(slot_long_row == ROW_W'(n), "R3 long row", slot_long_row, n);
            check(slot_short_row == ROW_W'(sr), "R4 short row", slot_short_row, sr);
            check(slot_short_ok == sok, "R4 short ok", slot_short_ok, sok);
            if (n == 0) begin
                // R2: start while busy must not reconfigure
                cfg_rows = ROW_W'(2); cfg_offset = ROW_W'(1); start = 1'b1;
                cyc();
                start = 1'b0;
                check(slot_long_row == 0 && slot_short_row == ROW_W'(sr),
                      "R2 start ignored while busy", slot_short_row, sr);
            end
            // R5: junk into column 1 first, overwritten later
            write_both(1, 16'hDEAD, 16'hBEEF);
            for (int c = NCOLS - 1; c >= 1; c--)
                write_both(c, up_val(n, c), lo_val(sr, c));
            // R6: out-of-range column marks nothing
            write_both(7, 16'h0BAD, 16'h0BAD);
            check(out_valid === 1'b0 && filling === 1'b1, "R6 partial row silent", out_valid, 0);
            wr_up = 1'b1; wr_col = '0; wr_data = DW'(up_val(n, 0));
            if (sok) begin
                cyc();
                wr_up = 1'b0; wr_lo = 1'b1; wr_data = DW'(lo_val(sr, 0));
            end else begin
                wr_lo = 1'b1; // R7: ignored lower write in same cycle
            end
            cyc();
            wr_up = 1'b0; wr_lo = 1'b0;
            check(out_valid === 1'b0, "R6 no valid on completing cycle", out_valid, 0);
            cyc();
            check(out_valid === 1'b1, "R6 drain begins", out_valid, 1);
            for (int c = 0; c < NCOLS; c++) begin
                int eu, el;
                eu = up_val(n, c);
                el = sok ? lo_val(sr, c) : 0;
                check(out_valid === 1'b1 && out_col == COL_W'(c), "R8 column order", out_col, c);
                check(out_long_row == ROW_W'(n) && out_short_row == ROW_W'(sr),
                      "R8 row tags", out_short_row, sr);
                check(out_short_ok == sok, "R7 beat short ok", out_short_ok, sok);
                check(out_upper == DW'(eu), "R5 upper value", out_upper, eu);
                check(out_lower == DW'(el), sok ? "R5 lower value" : "R7 lower zeroed",
                      out_lower, el);
                if (((c + n) % 3) == 0) begin
                    out_ready = 1'b0;
                    // R10: writes during drain ignored
                    wr_up = 1'b1; wr_lo = 1'b1; wr_col = COL_W'(c); wr_data = 16'hFFFF;
                    cyc();
                    wr_up = 1'b0; wr_lo = 1'b0;
                    check(out_valid === 1'b1 && out_col == COL_W'(c), "R9 held beat", out_col, c);
                    check(out_upper == DW'(eu) && out_lower == DW'(el),
                          "R10 drain write ignored", out_upper, eu);
                end
                out_ready = 1'b1;
                cyc();
                out_ready = 1'b0;
            end
            if (n < rows - 1) begin
                check(filling === 1'b1 && out_valid === 1'b0, "R11 next slot fills", filling, 1);
            end else begin
                check(frame_done === 1'b1 && busy === 1'b0, "R11 frame done", frame_done, 1);
                cyc();
                check(frame_done === 1'b0 && out_valid === 1'b0, "R11 done single", frame_done, 0);
            end
        end
    endtask

    initial begin
        #600000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc();
        cyc();
        rst = 1'b0;
        cyc();
        check(busy === 1'b0 && filling === 1'b0, "R1 reset idle", busy, 0);
        check(out_valid === 1'b0 && frame_done === 1'b0, "R1 reset outputs", out_valid, 0);
        // R10: writes while idle leave no trace in the next frame's first slot
        wr_up = 1'b1; wr_col = '0; wr_data = 16'h7777;
        cyc();
        wr_up = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            run_frame(int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                      int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            cyc();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule